// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates four interrupt request lines on behalf of a small 8-bit CPU core. One line is critical and cannot be masked. The other three are maskable, and a global enable flag and a per-line mask bit gate each of them. Each line senses its input in its own way:

- The critical line needs a rising edge followed by a level that stays high.
- The high line latches a rising edge.
- The middle and low lines follow the level of their inputs.

Among the lines that are eligible, the block presents the highest-ranked one to the core as a request with a fixed 16-bit call vector. It waits for the core's acknowledge.

The core drives one-cycle command strobes to set and clear the global enable, and to write the mask bits. A mask write can also carry a bit that flushes the high line's latch. A status word shows the mask bits, the enable flag and the raw pending state of the three maskable lines. When the core accepts any request, the global enable drops. The handler then runs with the maskable lines closed until software enables them again.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the request output is low, the enable flag is clear, all three mask bits are set, and no line is pending, so the status word reads 0x07.
- R2: Priority from highest to lowest is critical, high, middle, low. Their call vectors are 0x0024, 0x003C, 0x0034 and 0x002C. Only the highest-ranked eligible line is presented.
- R3: The critical line is presented whatever the enable flag and the mask bits hold.
- R4: The critical line becomes pending on a low-to-high change of its input and is presented only while the input stays high. After it is accepted it does not fire again until its input has been low and then rises again.
- R5: The high line latches a low-to-high change of its input and stays pending after the input falls. An input held high does not set the latch again after acknowledge.
- R6: The middle and low lines are pending only while their inputs are high. A pulse that ends before the line is eligible leaves nothing behind.
- R7: The enable strobe sets the global enable and the disable strobe clears it. With the enable clear, no maskable line is presented.
- R8: A maskable line whose mask bit is set is never presented. Mask bit 0 belongs to the low line, bit 1 to the middle line and bit 2 to the high line, and the same positions apply in the mask write data.
- R9: Accepting any request (request high and acknowledge high at a clock edge) clears the global enable.
- R10: Accepting the high line clears its latch. A mask write with the flush bit set clears the latch without an acknowledge. A mask write without the flush bit leaves the latch alone.
- R11: The status word holds the mask bits in [2:0], the enable flag in [3], and the pending state in [4] for low, [5] for middle and [6] for high. Bit 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_in | input | 1 | Critical request line, non-maskable |
| hi_in | input | 1 | High-rank request, rising edge latched |
| mid_in | input | 1 | Middle-rank request, level |
| lo_in | input | 1 | Low-rank request, level |
| en_set | input | 1 | Strobe that sets the global enable |
| en_clr | input | 1 | Strobe that clears the global enable |
| mask_wr | input | 1 | Strobe that writes the mask bits |
| mask_data | input | 3 | New mask bits: [0] low, [1] middle, [2] high |
| mask_flush | input | 1 | With mask_wr, clears the high line's latch |
| irq_valid | output | 1 | Request to the core |
| irq_vector | output | VEC_W | Call vector of the presented line |
| irq_ack | input | 1 | Acknowledge from the core |
| status | output | 8 | Mask, enable and pending state |

## Verification
The properties assume that every request input is already synchronous to clk and changes only between edges. They also assume the core raises the acknowledge only while a request is shown, and that the enable and disable strobes are never raised in the same cycle. The stimulus drives every input just after a falling edge, keeps the enable and disable strobes mutually exclusive, and raises the acknowledge only after it has seen a request. The bench walks through all combinations of enable state, mask value, high-line latch and the two level lines. Around that sweep, directed sequences hold lines high across an acknowledge and drop them before it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int LINES  = 4;
  localparam int MASK_W = LINES - 1;

  typedef enum logic [1:0] {
    SENSE_EDGE_LEVEL,
    SENSE_LATCH,
    SENSE_LEVEL
  } sense_e;

  // line index 0 ranks highest: 0 critical, 1 high, 2 middle, 3 low
  function automatic sense_e sense_of(input int idx);
    if (idx == 0) return SENSE_EDGE_LEVEL;
    if (idx == 1) return SENSE_LATCH;
    return SENSE_LEVEL;
  endfunction

  // critical sits at the base; the others step down by 8 with falling rank
  function automatic logic [15:0] vector_of(input int idx);
    if (idx == 0) return 16'h0024;
    return 16'(32'h0024 + 8 * (LINES - idx));
  endfunction

  // mask bit that guards a maskable line
  function automatic int mask_bit_of(input int idx);
    return LINES - 1 - idx;
  endfunction

endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_ctrl_pkg::*;
#(
  parameter sense_e MODE = SENSE_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic take,
  input  logic flush,
  output logic pending
);

  logic prev_q;
  logic rise_w;

  // reset high so an input already high at reset is not taken as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= req_in;
  end

  assign rise_w = req_in & ~prev_q;

  generate
    if (MODE == SENSE_EDGE_LEVEL) begin : g_edge_level
      logic hold_q;
      logic unused_flush;
      assign unused_flush = flush;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hold_q <= 1'b0;
        else if (rise_w)           hold_q <= 1'b1;
        else if (take || !req_in)  hold_q <= 1'b0;
      end

      assign pending = hold_q & req_in;

      AST_CRIT_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_in) |=> !pending); // R4
      AST_CRIT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> req_in); // R4
    end else if (MODE == SENSE_LATCH) begin : g_latch
      logic hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hold_q <= 1'b0;
        else if (rise_w)         hold_q <= 1'b1;
        else if (take || flush)  hold_q <= 1'b0;
      end

      assign pending = hold_q;

      AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !take && !flush) |=> pending); // R5
      AST_LATCH_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(req_in)); // R5
      AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((take || flush) && !req_in) |=> !pending); // R10
    end else begin : g_level
      logic unused_sig;
      assign unused_sig = take ^ flush ^ rise_w;
      assign pending = req_in;
    end
  endgenerate

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              accept,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic [LINES-1:0]  pend,
  output logic [LINES-1:0]  eligible,
  output logic              en_q,
  output logic [MASK_W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (accept)  en_q <= 1'b0;
    else if (en_clr)  en_q <= 1'b0;
    else if (en_set)  en_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign eligible[0] = pend[0];

  generate
    for (genvar i = 1; i < LINES; i++) begin : g_open
      assign eligible[i] = pend[i] & en_q & ~mask_q[mask_bit_of(i)];
    end
  endgenerate

  AST_ACCEPT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !en_q); // R9
  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set && !en_clr && !accept) |=> en_q); // R7
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !en_q); // R7
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data))); // R8

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic [LINES-1:0] eligible,
  output logic [LINES-1:0] grant,
  output logic             any,
  output logic [VW-1:0]    vector
);

  always_comb begin
    grant  = '0;
    any    = 1'b0;
    vector = '0;
    for (int i = 0; i < LINES; i++) begin
      if (eligible[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
        vector   = VW'(vector_of(i));
      end
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crit_in,
  input  logic              hi_in,
  input  logic              mid_in,
  input  logic              lo_in,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              mask_flush,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  output logic [7:0]        status
);

  localparam logic [VEC_W-1:0] CRIT_VEC = VEC_W'(vector_of(0));
  localparam logic [VEC_W-1:0] HI_VEC   = VEC_W'(vector_of(1));

  logic [LINES-1:0]  line_in;
  logic [LINES-1:0]  pend;
  logic [LINES-1:0]  take;
  logic [LINES-1:0]  eligible;
  logic [LINES-1:0]  grant;
  logic              accept;
  logic              flush_hi;
  logic              en_q;
  logic [MASK_W-1:0] mask_q;

  assign line_in  = {lo_in, mid_in, hi_in, crit_in};
  assign accept   = irq_valid & irq_ack;
  assign take     = grant & {LINES{accept}};
  assign flush_hi = mask_wr & mask_flush;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      irq_sense #(.MODE(sense_of(i))) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (line_in[i]),
        .take    (take[i]),
        .flush   ((i == 1) ? flush_hi : 1'b0),
        .pending (pend[i])
      );
    end
  endgenerate

  irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .accept    (accept),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .pend      (pend),
    .eligible  (eligible),
    .en_q      (en_q),
    .mask_q    (mask_q)
  );

  irq_pick #(.VW(VEC_W)) u_pick (
    .eligible (eligible),
    .grant    (grant),
    .any      (irq_valid),
    .vector   (irq_vector)
  );

  assign status = {1'b0, pend[1], pend[2], pend[3], en_q, mask_q};

  AST_CRIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> (irq_valid && irq_vector == CRIT_VEC)); // R3
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !pend[0]) |-> en_q); // R7
  AST_HI_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector == HI_VEC) |-> (en_q && !mask_q[2])); // R8
  AST_HI_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take[1] && !hi_in) |=> !status[6]); // R10

endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crit_in = 1'b0, hi_in = 1'b0, mid_in = 1'b0, lo_in = 1'b0;
  logic        en_set = 1'b0, en_clr = 1'b0, mask_wr = 1'b0, mask_flush = 1'b0;
  logic [2:0]  mask_data = 3'b000;
  logic        irq_ack = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic [7:0]  status;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .crit_in(crit_in), .hi_in(hi_in), .mid_in(mid_in),
    .lo_in(lo_in), .en_set(en_set), .en_clr(en_clr), .mask_wr(mask_wr),
    .mask_data(mask_data), .mask_flush(mask_flush), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    en_set = 0; en_clr = 0; mask_wr = 0; mask_flush = 0; irq_ack = 0;
  endtask

  // vector from rank: 0 critical, 1 low, 2 middle, 3 high
  function automatic int vec_of_rank(input int rank);
    return 32'h24 + 8 * rank;
  endfunction

  task automatic ack_once();
    irq_ack = 1; cyc(); irq_ack = 0;
  endtask

  task automatic expect_req(input bit v, input int vec, input string req);
    chk(irq_valid == v, req, int'(irq_valid), int'(v));
    if (v) chk(irq_vector == 16'(vec), req, int'(irq_vector), vec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(status == 8'h07, "R1 status", int'(status), 8'h07);
    chk(irq_valid == 1'b0, "R1 request", int'(irq_valid), 0);

    // sweep: enable x mask x high latch x middle/low levels
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        for (int h = 0; h < 2; h++) begin
          for (int lv = 0; lv < 4; lv++) begin
            bit mid_l, lo_l, hi_ok, mid_ok, lo_ok, ev;
            int ex_vec, ex_stat;
            mid_l = lv[1]; lo_l = lv[0];
            mask_wr = 1; mask_data = 3'(m); mask_flush = 1;
            en_set = (e != 0); en_clr = (e == 0);
            hi_in = (h != 0); mid_in = mid_l; lo_in = lo_l;
            cyc();
            idle(); hi_in = 0;
            cyc();
            hi_ok  = (h != 0) && (e != 0) && !m[2];
            mid_ok = mid_l && (e != 0) && !m[1];
            lo_ok  = lo_l && (e != 0) && !m[0];
            ev = hi_ok || mid_ok || lo_ok;
            ex_vec = hi_ok ? vec_of_rank(3) : mid_ok ? vec_of_rank(2) : vec_of_rank(1);
            ex_stat = (h << 6) | (int'(mid_l) << 5) | (int'(lo_l) << 4) | (e << 3) | m;
            // R2 R5 R6 R7 R8 selection; R11 status layout
            expect_req(ev, ex_vec, "R2/R6/R7/R8 sweep");
            chk(status == 8'(ex_stat), "R11 status sweep", int'(status), ex_stat);
            if (ev) begin
              ack_once();
              // R9 enable gone; R10 latch gone only if high was taken
              chk(status[3] == 1'b0, "R9 enable after accept", int'(status[3]), 0);
              chk(status[6] == ((h != 0) && !hi_ok), "R10 latch after accept",
                  int'(status[6]), int'((h != 0) && !hi_ok));
              chk(irq_valid == 1'b0, "R9 no request after accept", int'(irq_valid), 0);
            end
          end
        end
      end
    end
    mid_in = 0; lo_in = 0;
    mask_wr = 1; mask_data = 3'b111; mask_flush = 1; en_clr = 1;
    cyc(); idle();

    // R3 critical passes with enable off and all masked
    crit_in = 1; cyc();
    expect_req(1, 32'h24, "R3 critical while closed");
    crit_in = 0; cyc();
    expect_req(0, 0, "R4 critical dropped before ack");

    // R2 critical beats everything, R4 no refire while held
    mask_wr = 1; mask_data = 3'b000; en_set = 1;
    mid_in = 1; lo_in = 1; hi_in = 1; crit_in = 1;
    cyc(); idle(); hi_in = 0;
    expect_req(1, 32'h24, "R2 critical first");
    ack_once();
    expect_req(0, 0, "R4 held critical after accept");
    en_set = 1; cyc(); idle();
    expect_req(1, 32'h3C, "R2 high after critical");
    ack_once();
    en_set = 1; cyc(); idle();
    expect_req(1, 32'h34, "R2 middle after high");
    mid_in = 0; cyc();
    expect_req(1, 32'h2C, "R2 low after middle");
    lo_in = 0; cyc();
    expect_req(0, 0, "R4 critical still held, no refire");
    crit_in = 0; cyc();
    crit_in = 1; cyc();
    expect_req(1, 32'h24, "R4 refire after low");
    ack_once(); crit_in = 0;

    // R5 held high line does not set again after acknowledge
    en_set = 1; hi_in = 1; cyc(); idle();
    expect_req(1, 32'h3C, "R5 high latched");
    ack_once();
    en_set = 1; cyc(); idle();
    expect_req(0, 0, "R5 held high no refire");
    hi_in = 0; cyc();

    // R10 mask write without flush keeps latch, with flush clears it
    hi_in = 1; en_clr = 1; cyc(); idle(); hi_in = 0; cyc();
    chk(status[6] == 1'b1, "R5 latch after fall", int'(status[6]), 1);
    mask_wr = 1; mask_data = 3'b000; cyc(); idle();
    chk(status[6] == 1'b1, "R10 plain mask write", int'(status[6]), 1);
    mask_wr = 1; mask_flush = 1; cyc(); idle();
    chk(status[6] == 1'b0, "R10 flush", int'(status[6]), 0);

    // R6 a level pulse leaves nothing behind
    mid_in = 1; lo_in = 1; cyc(); mid_in = 0; lo_in = 0;
    en_set = 1; cyc(); idle();
    expect_req(0, 0, "R6 pulse gone");
    chk(status[5:4] == 2'b00, "R6 pending bits", int'(status[5:4]), 0);

    // R7 disable closes an active request
    lo_in = 1; cyc();
    expect_req(1, 32'h2C, "R7 open");
    en_clr = 1; cyc(); idle();
    expect_req(0, 0, "R7 closed");
    lo_in = 0; cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule